// File: doc/BRIEF.md
# Analog Input Scan Controller

This block is the register-side sequencer of a 32-channel analog-to-digital front end. Software programs a first and a last channel, an inter-channel settling interval and a scan mode through an 8-bit register port. A write to the start address then runs a whole conversion sequence with no further software action. For each channel the block asks an external converter for one conversion and waits for its done strobe. It keeps the 16-bit result for software to read as two bytes.

The sequence steps upward from the first channel to the last one. When the last channel is numerically below the first, the count wraps from channel 31 to channel 0. With scan mode off, a start converts only the first channel. A busy flag covers the whole sequence. At the end, an enabled interrupt is raised and stays pending until software clears it. Several registers have fixed values after reset, so software can probe for the block.

Top module: `ai_scan_ctrl`

## Requirements
- R1: After reset, address 0x7 reads 0x80, address 0x8 reads 0x60, address 0x9 reads 0x00 and irq_o is low.
- R2: The bound registers at 0x2 (first channel) and 0x3 (last channel) keep only bits 4:0 of the written value. Bits 7:5 read as zero, so 0x80 reads back 0x00 and 0xFF reads back 0x1F.
- R3: With scan mode on (0x7 bit 2), a write to 0x0 from idle issues exactly one conv_req_o pulse per channel. The channels run from the first to the last in ascending order, modulo 32, so last < first wraps through 31 to 0 and last == first gives one conversion.
- R4: With scan mode off, a start issues exactly one request, for the first channel, whatever the last-channel register holds.
- R5: Reading 0x0 returns bits 7:0 of the most recently captured conv_data_i, and reading 0x1 returns bits 15:8.
- R6: Bit 7 of both 0x8 and 0xB reads 1 from the cycle after the start write until the final sample is captured. Bits 6:5 of 0x8 always read 1, and bits 4:0 of 0x8 give the channel being converted.
- R7: Within a scan, the next request rises exactly (4 − S)·STEP_CYCLES + 2 cycles after the cycle in which conv_done_i was high. S is 0xB bits 5:4, where 0 is the longest interval and 3 the shortest.
- R8: The settings register 0xB reads back bits 5:0 as written and bit 6 as 0 while idle. Writing 0x0C reads back 0x0C.
- R9: Register 0x9 holds the interrupt enable in bit 7 and the clock enable and clock select in bits 1:0; other bits read 0. At scan end, if the enable is set, irq_o rises and stays high until a write to 0x8 with bit 3 set. With the enable clear, irq_o stays low.
- R10: A start write while a scan is busy is ignored: the running sequence neither restarts nor gains requests.
- R11: Address 0x7 reads bit 7 as 1, bit 3 as the stored FIFO enable, bit 2 as the stored scan mode, and all other bits as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 4 | Register address |
| wr_i | input | 1 | Register write strobe |
| rd_i | input | 1 | Register read strobe; rdata_o is valid the next cycle |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, registered |
| conv_req_o | output | 1 | One-cycle conversion request |
| conv_chan_o | output | CHAN_W | Channel to convert |
| conv_done_i | input | 1 | Converter result valid strobe |
| conv_data_i | input | 16 | Converter result |
| irq_o | output | 1 | Scan-complete interrupt, level |

## Verification
The hardest condition to reach is the wrap from channel 31 to channel 0 together with exact interval timing. The bench reaches it by sweeping every first channel. Each first channel is paired with last-channel offsets of 0, 1, 5 and −1, and the −1 offset forces a full 32-channel wrap. The interval select rotates through all four settings during the sweep. A converter stub logs the cycle of every request and every done strobe, so that each gap and each channel in order can be compared with arithmetic. A second start issued in the middle of a scan checks that a busy sequence ignores it.

// File: rtl/ai_scan_pkg.sv
package ai_scan_pkg;
  localparam int unsigned RES_W = 16;

  localparam logic [3:0] A_RES_LO = 4'h0;
  localparam logic [3:0] A_RES_HI = 4'h1;
  localparam logic [3:0] A_FIRST  = 4'h2;
  localparam logic [3:0] A_LAST   = 4'h3;
  localparam logic [3:0] A_FIFO   = 4'h7;
  localparam logic [3:0] A_CTRL   = 4'h8;
  localparam logic [3:0] A_INT    = 4'h9;
  localparam logic [3:0] A_CFG    = 4'hB;

  typedef enum logic [1:0] {SQ_IDLE, SQ_REQ, SQ_WAIT, SQ_GAP} seq_state_e;

  function automatic int gap_cycles(input logic [1:0] sel, input int step);
    return (4 - int'(sel)) * step;
  endfunction
endpackage

// File: rtl/ai_scan_seq.sv
module ai_scan_seq
  import ai_scan_pkg::*;
#(
  parameter int unsigned CHAN_W      = 5,
  parameter int unsigned STEP_CYCLES = 50
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              scan_en_i,
  input  logic [CHAN_W-1:0] first_i,
  input  logic [CHAN_W-1:0] last_i,
  input  logic [1:0]        gap_sel_i,
  output logic              conv_req_o,
  output logic [CHAN_W-1:0] conv_chan_o,
  input  logic              conv_done_i,
  input  logic [RES_W-1:0]  conv_data_i,
  output logic              busy_o,
  output logic [CHAN_W-1:0] cur_chan_o,
  output logic [RES_W-1:0]  result_o,
  output logic              scan_done_o
);
  localparam int unsigned GAP_MAX = 4 * STEP_CYCLES;
  localparam int unsigned GAP_W   = $clog2(GAP_MAX + 1);

  seq_state_e        state_q;
  logic [CHAN_W-1:0] cur_q, last_q;
  logic              single_q;
  logic [1:0]        sel_q;
  logic [GAP_W-1:0]  cnt_q;
  logic [RES_W-1:0]  res_q;
  logic              done_q;
  logic              at_end;

  assign at_end = single_q || (cur_q == last_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= SQ_IDLE;
      cur_q    <= '0;
      last_q   <= '0;
      single_q <= 1'b0;
      sel_q    <= '0;
      cnt_q    <= '0;
      res_q    <= '0;
      done_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        SQ_IDLE: if (start_i) begin
          cur_q    <= first_i;
          last_q   <= last_i;
          single_q <= !scan_en_i;
          sel_q    <= gap_sel_i;
          state_q  <= SQ_REQ;
        end
        SQ_REQ: state_q <= SQ_WAIT;
        SQ_WAIT: if (conv_done_i) begin
          res_q <= conv_data_i;
          if (at_end) begin
            state_q <= SQ_IDLE;
            done_q  <= 1'b1;
          end else begin
            cur_q   <= cur_q + 1'b1;  // wraps modulo channel count
            cnt_q   <= GAP_W'(gap_cycles(sel_q, int'(STEP_CYCLES)));
            state_q <= SQ_GAP;
          end
        end
        SQ_GAP: begin
          if (cnt_q == '0) state_q <= SQ_REQ;
          else             cnt_q   <= cnt_q - 1'b1;
        end
        default: state_q <= SQ_IDLE;
      endcase
    end
  end

  assign conv_req_o  = (state_q == SQ_REQ);
  assign conv_chan_o = cur_q;
  assign busy_o      = (state_q != SQ_IDLE);
  assign cur_chan_o  = cur_q;
  assign result_o    = res_q;
  assign scan_done_o = done_q;

  assert_req_pulse_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_req_o |=> !conv_req_o);
  assert_step_up_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == SQ_WAIT && conv_done_i && !at_end) |=> cur_q == CHAN_W'($past(cur_q) + 1'b1));
  assert_gap_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == SQ_GAP && cnt_q != '0) |=> (state_q == SQ_GAP && !conv_req_o));
  assert_start_ignored_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && state_q == SQ_WAIT && !conv_done_i) |=> (state_q == SQ_WAIT && $stable(cur_q)));
endmodule

// File: rtl/ai_scan_regs.sv
module ai_scan_regs
  import ai_scan_pkg::*;
#(
  parameter int unsigned CHAN_W = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [3:0]        addr_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [7:0]        wdata_i,
  output logic [7:0]        rdata_o,
  input  logic              busy_i,
  input  logic [CHAN_W-1:0] cur_chan_i,
  input  logic [RES_W-1:0]  result_i,
  input  logic              scan_done_i,
  output logic              start_o,
  output logic              scan_en_o,
  output logic [CHAN_W-1:0] first_o,
  output logic [CHAN_W-1:0] last_o,
  output logic [1:0]        gap_sel_o,
  output logic              irq_o
);
  logic [CHAN_W-1:0] first_q, last_q;
  logic              fifo_en_q, scan_en_q;
  logic [5:0]        cfg_q;
  logic              int_en_q, clk_en_q, clk_sel_q, pend_q;
  logic [7:0]        rdata_q, rd_mux;
  logic              irq_clr;
  logic              unused_wbit;

  assign unused_wbit = wdata_i[6];
  assign irq_clr     = wr_i && (addr_i == A_CTRL) && wdata_i[3];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      first_q   <= '0;
      last_q    <= '0;
      fifo_en_q <= 1'b0;
      scan_en_q <= 1'b0;
      cfg_q     <= '0;
      int_en_q  <= 1'b0;
      clk_en_q  <= 1'b0;
      clk_sel_q <= 1'b0;
    end else if (wr_i) begin
      unique case (addr_i)
        A_FIRST: first_q <= wdata_i[CHAN_W-1:0];
        A_LAST:  last_q  <= wdata_i[CHAN_W-1:0];
        A_FIFO: begin
          fifo_en_q <= wdata_i[3];
          scan_en_q <= wdata_i[2];
        end
        A_INT: begin
          int_en_q  <= wdata_i[7];
          clk_en_q  <= wdata_i[1];
          clk_sel_q <= wdata_i[0];
        end
        A_CFG:   cfg_q <= wdata_i[5:0];
        default: ;
      endcase
    end
  end

  // set wins over a simultaneous clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      pend_q <= 1'b0;
    else if (scan_done_i && int_en_q) pend_q <= 1'b1;
    else if (irq_clr)                 pend_q <= 1'b0;
  end

  always_comb begin
    unique case (addr_i)
      A_RES_LO: rd_mux = result_i[7:0];
      A_RES_HI: rd_mux = result_i[15:8];
      A_FIRST:  rd_mux = 8'(first_q);
      A_LAST:   rd_mux = 8'(last_q);
      A_FIFO:   rd_mux = {1'b1, 3'b000, fifo_en_q, scan_en_q, 2'b00};
      A_CTRL:   rd_mux = {busy_i, 2'b11, 5'(cur_chan_i)};
      A_INT:    rd_mux = {int_en_q, 5'b00000, clk_en_q, clk_sel_q};
      A_CFG:    rd_mux = {busy_i, 1'b0, cfg_q};
      default:  rd_mux = 8'h00;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_q <= '0;
    else if (rd_i) rdata_q <= rd_mux;
  end

  assign rdata_o   = rdata_q;
  assign start_o   = wr_i && (addr_i == A_RES_LO);
  assign scan_en_o = scan_en_q;
  assign first_o   = first_q;
  assign last_o    = last_q;
  assign gap_sel_o = cfg_q[5:4];
  assign irq_o     = pend_q;

  assert_bound_pad_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && (addr_i == A_FIRST || addr_i == A_LAST)) |=> rdata_o[7:5] == 3'b000);
  assert_irq_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !irq_clr) |=> irq_o);
  assert_irq_gated_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!irq_o && !(scan_done_i && int_en_q)) |=> !irq_o);
endmodule

// File: rtl/ai_scan_ctrl.sv
module ai_scan_ctrl
  import ai_scan_pkg::*;
#(
  parameter int unsigned CHAN_W      = 5,
  parameter int unsigned STEP_CYCLES = 50
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [3:0]        addr_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [7:0]        wdata_i,
  output logic [7:0]        rdata_o,
  output logic              conv_req_o,
  output logic [CHAN_W-1:0] conv_chan_o,
  input  logic              conv_done_i,
  input  logic [15:0]       conv_data_i,
  output logic              irq_o
);
  logic              start, scan_en, busy, scan_done;
  logic [CHAN_W-1:0] first_chan, last_chan, cur_chan;
  logic [1:0]        gap_sel;
  logic [RES_W-1:0]  result;

  ai_scan_regs #(.CHAN_W(CHAN_W)) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .addr_i      (addr_i),
    .wr_i        (wr_i),
    .rd_i        (rd_i),
    .wdata_i     (wdata_i),
    .rdata_o     (rdata_o),
    .busy_i      (busy),
    .cur_chan_i  (cur_chan),
    .result_i    (result),
    .scan_done_i (scan_done),
    .start_o     (start),
    .scan_en_o   (scan_en),
    .first_o     (first_chan),
    .last_o      (last_chan),
    .gap_sel_o   (gap_sel),
    .irq_o       (irq_o)
  );

  ai_scan_seq #(.CHAN_W(CHAN_W), .STEP_CYCLES(STEP_CYCLES)) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start),
    .scan_en_i   (scan_en),
    .first_i     (first_chan),
    .last_i      (last_chan),
    .gap_sel_i   (gap_sel),
    .conv_req_o  (conv_req_o),
    .conv_chan_o (conv_chan_o),
    .conv_done_i (conv_done_i),
    .conv_data_i (conv_data_i),
    .busy_o      (busy),
    .cur_chan_o  (cur_chan),
    .result_o    (result),
    .scan_done_o (scan_done)
  );

  assert_req_while_busy_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_req_o |-> busy);
  assert_done_ends_busy_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    scan_done |-> !busy);
endmodule

// File: tb/ai_scan_ctrl_test.sv
module ai_scan_ctrl_test;
  localparam int STEP = 3;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [3:0]  addr = '0;
  logic        wr = 1'b0, rd = 1'b0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic        conv_req, conv_done = 1'b0, irq;
  logic [4:0]  conv_chan;
  logic [15:0] conv_data = '0;

  int n_chk = 0, n_fail = 0;
  int cyc = 0;
  int req_n = 0, done_n = 0, samp = 0, lat = 0;
  int req_chan [0:63];
  int req_cyc  [0:63];
  int done_cyc [0:63];
  logic [4:0]  pend_chan = '0;
  logic [15:0] last_data = '0;

  ai_scan_ctrl #(.CHAN_W(5), .STEP_CYCLES(STEP)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .addr_i(addr), .wr_i(wr), .rd_i(rd),
    .wdata_i(wdata), .rdata_o(rdata), .conv_req_o(conv_req),
    .conv_chan_o(conv_chan), .conv_done_i(conv_done),
    .conv_data_i(conv_data), .irq_o(irq)
  );

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // converter stub: done three cycles after the request
  always @(negedge clk) begin
    conv_done = 1'b0;
    if (lat == 1) begin
      conv_data = {3'b101, pend_chan, samp[7:0]};
      last_data = conv_data;
      conv_done = 1'b1;
      if (done_n < 64) done_cyc[done_n] = cyc;
      done_n = done_n + 1;
      samp = samp + 1;
    end
    if (lat != 0) lat = lat - 1;
    if (conv_req) begin
      pend_chan = conv_chan;
      lat = 3;
      if (req_n < 64) begin
        req_chan[req_n] = int'(conv_chan);
        req_cyc[req_n]  = cyc;
      end
      req_n = req_n + 1;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [3:0] a, input logic [7:0] d);
    addr = a; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [3:0] a, output logic [7:0] d);
    addr = a; rd = 1'b1;
    @(negedge clk);
    rd = 1'b0;
    d = rdata;
  endtask

  task automatic finish_up();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  task automatic run_scan(input int lo, input int hi, input bit scan, input int sel,
                          input bit ien, input bit restart);
    logic [7:0] d;
    int n, g, polls;
    wr_reg(4'h2, 8'(lo));
    wr_reg(4'h3, 8'(hi));
    wr_reg(4'h7, {5'b0, scan, 2'b00});
    wr_reg(4'hB, {2'b00, 2'(sel), 4'b0000});
    wr_reg(4'h9, {ien, 7'b0});
    wr_reg(4'h8, 8'h08);
    req_n = 0; done_n = 0;
    wr_reg(4'h0, 8'hFF);
    rd_reg(4'h8, d);
    chk(d[7] == 1'b1 && d[6:5] == 2'b11, "R6 busy after start", int'(d), 8'hE0);
    rd_reg(4'hB, d);
    chk(d[7] == 1'b1, "R6 settings busy mirror", int'(d), 8'h80);
    if (restart) begin
      wr_reg(4'h0, 8'h00);  // R10: must be ignored
      wr_reg(4'h0, 8'h00);
    end
    polls = 0;
    do begin
      rd_reg(4'h8, d);
      polls++;
    end while (d[7] && polls < 5000);
    chk(!d[7], "R6 busy clears", int'(d), 0);
    n = scan ? ((hi - lo + 32) % 32) + 1 : 1;
    chk(req_n == n, scan ? (restart ? "R10 request count" : "R3 request count")
                         : "R4 single conversion", req_n, n);
    for (int i = 0; i < n && i < req_n; i++) begin
      chk(req_chan[i] == (lo + i) % 32, "R3 channel order", req_chan[i], (lo + i) % 32);
      if (i > 0) begin
        g = (4 - sel) * STEP + 2;
        chk(req_cyc[i] - done_cyc[i-1] == g, "R7 interval", req_cyc[i] - done_cyc[i-1], g);
      end
    end
    chk(d[4:0] == 5'((lo + n - 1) % 32), "R6 current channel", int'(d[4:0]), (lo + n - 1) % 32);
    rd_reg(4'h0, d);
    chk(d == last_data[7:0], "R5 result low byte", int'(d), int'(last_data[7:0]));
    rd_reg(4'h1, d);
    chk(d == last_data[15:8], "R5 result high byte", int'(d), int'(last_data[15:8]));
    chk(irq == ien, "R9 irq at scan end", int'(irq), int'(ien));
  endtask

  initial begin
    #(4 * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_up();
  end

  initial begin
    logic [7:0] d;
    repeat (4) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    // R1 reset values
    chk(irq == 1'b0, "R1 irq after reset", int'(irq), 0);
    rd_reg(4'h7, d); chk(d == 8'h80, "R1 fifo status", int'(d), 8'h80);
    rd_reg(4'h8, d); chk(d == 8'h60, "R1 status", int'(d), 8'h60);
    rd_reg(4'h9, d); chk(d == 8'h00, "R1 interrupt reg", int'(d), 0);
    // R2 bound masking
    wr_reg(4'h2, 8'h80); rd_reg(4'h2, d); chk(d == 8'h00, "R2 first 0x80", int'(d), 0);
    wr_reg(4'h3, 8'hFF); rd_reg(4'h3, d); chk(d == 8'h1F, "R2 last 0xFF", int'(d), 8'h1F);
    for (int v = 0; v < 256; v += 7) begin
      wr_reg(4'h2, 8'(v)); rd_reg(4'h2, d);
      chk(d == 8'(v & 31), "R2 first sweep", int'(d), v & 31);
    end
    // R8 settings readback
    for (int v = 0; v < 256; v += 5) begin
      wr_reg(4'hB, 8'(v)); rd_reg(4'hB, d);
      chk(d == 8'(v & 8'h3F), "R8 settings readback", int'(d), v & 8'h3F);
    end
    wr_reg(4'hB, 8'h0C); rd_reg(4'hB, d); chk(d == 8'h0C, "R8 unipolar 10V", int'(d), 8'h0C);
    // R11 fifo control readback
    wr_reg(4'h7, 8'h0E); rd_reg(4'h7, d); chk(d == 8'h8C, "R11 fifo en+scan", int'(d), 8'h8C);
    wr_reg(4'h7, 8'h02); rd_reg(4'h7, d); chk(d == 8'h80, "R11 fifo reset only", int'(d), 8'h80);
    // R9 interrupt register fields
    wr_reg(4'h9, 8'hFF); rd_reg(4'h9, d); chk(d == 8'h83, "R9 int reg fields", int'(d), 8'h83);
    wr_reg(4'h9, 8'h00);
    // R3/R7 sweep of first channel and spans
    for (int lo = 0; lo < 32; lo++) begin
      run_scan(lo, lo, 1'b1, lo % 4, 1'b0, 1'b0);
      run_scan(lo, (lo + 1) % 32, 1'b1, (lo + 1) % 4, 1'b0, 1'b0);
      run_scan(lo, (lo + 5) % 32, 1'b1, (lo + 2) % 4, 1'b0, 1'b0);
      run_scan(lo, (lo + 31) % 32, 1'b1, (lo + 3) % 4, 1'b0, 1'b0);
    end
    // R4 scan off
    run_scan(3, 20, 1'b0, 1, 1'b0, 1'b0);
    run_scan(30, 2, 1'b0, 2, 1'b0, 1'b0);
    // R10 start while busy
    run_scan(0, 7, 1'b1, 0, 1'b0, 1'b1);
    // R9 interrupt set, hold, clear
    run_scan(28, 1, 1'b1, 3, 1'b1, 1'b0);
    repeat (10) @(negedge clk);
    chk(irq == 1'b1, "R9 irq holds", int'(irq), 1);
    wr_reg(4'h8, 8'h00);
    chk(irq == 1'b1, "R9 clear needs bit 3", int'(irq), 1);
    wr_reg(4'h8, 8'h08);
    @(negedge clk);
    chk(irq == 1'b0, "R9 irq cleared", int'(irq), 0);
    run_scan(5, 6, 1'b1, 2, 1'b0, 1'b0);
    repeat (5) @(negedge clk);
    chk(irq == 1'b0, "R9 disabled stays low", int'(irq), 0);
    finish_up();
  end
endmodule